// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap finite impulse response filter that works on blocks of three consecutive samples. Every clock that carries a valid block, it takes the samples x(3k), x(3k+1) and x(3k+2) on three lanes. It returns y(3k), y(3k+1) and y(3k+2) on three result lanes one clock later. The filter therefore processes three samples per clock. The arithmetic is replicated once per lane instead of running the clock three times faster.

Each output sums three coefficient-weighted samples: coefficient A weights the newest sample, B the one before it, and C the oldest. The two oldest lanes need samples from the previous block, x(3k−1) and x(3k−2). These come from two registers loaded from the last two lanes of the previous valid block. Converting a serial stream into blocks, and back, is left to the surrounding logic.

Top module: `fir3p_block_filter`

## Requirements
- R1: Lane 0 result equals A·x(3k) + B·x(3k−1) + C·x(3k−2), where x(3k−1) and x(3k−2) are lanes 2 and 1 of the previous valid block.
- R2: Lane 1 result equals A·x(3k+1) + B·x(3k) + C·x(3k−1), where x(3k−1) is lane 2 of the previous valid block.
- R3: Lane 2 result equals A·x(3k+2) + B·x(3k+1) + C·x(3k), using only the current block.
- R4: Exactly the last two samples of each valid block are carried over: lane 2 becomes x(3k−1) and lane 1 becomes x(3k−2) of the next valid block.
- R5: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. The results of that block are present in that same cycle.
- R6: After a synchronous active-low reset, `out_valid` is low, all result lanes read zero, and the carried samples are zero. The first block after reset is therefore filtered as if preceded by zeros.
- R7: While `in_valid` is low, sample inputs are ignored and the carried samples are kept. The next valid block is filtered against the last valid block, whatever the lanes carried during the gap.
- R8: While `in_valid` is low, the result lanes keep the results of the last valid block, and `out_valid` stays low.
- R9: Data and coefficients are 16-bit two's complement. Results are 34-bit two's complement and exact for every input, including all operands at −32768.
- R10: Coefficients are sampled together with the block. A coefficient change applies from the block presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A block of three samples is present |
| in_x0 | input | 16 | Sample x(3k), signed |
| in_x1 | input | 16 | Sample x(3k+1), signed |
| in_x2 | input | 16 | Sample x(3k+2), signed |
| coef_a | input | 16 | Weight of the newest sample, signed |
| coef_b | input | 16 | Weight of the sample one step back, signed |
| coef_c | input | 16 | Weight of the sample two steps back, signed |
| out_valid | output | 1 | Result lanes hold a new block |
| out_y0 | output | 34 | Result y(3k), signed |
| out_y1 | output | 34 | Result y(3k+1), signed |
| out_y2 | output | 34 | Result y(3k+2), signed |

## Verification
The only internal state that the result lanes cannot show at once is the pair of carried samples. A wrong carry register, a wrong lane routing into it, or a missed hold during a gap does not affect lane 2. It shows up in lanes 0 and 1 of the very next valid block. For that reason every gap in the stimulus is followed by a block with nonzero B and C, and the gaps drive junk onto the sample lanes. A fault in the output registers or the valid flag is visible one clock after the block that triggers it, at the latest in the first idle cycle.

// File: rtl/fir3p_pkg.sv
// Package: shared structure constants for the three-lane block FIR filter.
// Assumes: the lane count and tap count are fixed by the filter's equations;
// widths remain parameters on the modules themselves.
package fir3p_pkg;
    // Samples handled per block clock.
    localparam int LANES = 3;
    // Filter taps (weights A, B, C).
    localparam int TAPS = 3;
    // Samples visible to one block: carried ones plus the current lanes.
    localparam int WIN = LANES + TAPS - 1;
    // Samples carried from one block to the next.
    localparam int CARRY = TAPS - 1;
endpackage

// File: rtl/fir3p_tap_sum.sv
// Module: one lane's arithmetic, three products summed into a wider result.
// Assumes: operands are two's complement. ACC_W leaves room for the sum of
// TAPS full-scale products, so nothing overflows.
module fir3p_tap_sum #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34
) (
    input  logic signed [DATA_W-1:0] s_new,
    input  logic signed [DATA_W-1:0] s_mid,
    input  logic signed [DATA_W-1:0] s_old,
    input  logic signed [COEF_W-1:0] k_new,
    input  logic signed [COEF_W-1:0] k_mid,
    input  logic signed [COEF_W-1:0] k_old,
    output logic signed [ACC_W-1:0]  sum
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] p_new, p_mid, p_old;
    logic [ACC_W-1:0] e_new, e_mid, e_old;

    // Form the three full-precision products.
    always_comb begin
        p_new = s_new * k_new;
        p_mid = s_mid * k_mid;
        p_old = s_old * k_old;
    end

    // Sign-extend each product to the result width.
    always_comb begin
        e_new = {{EXT_W{p_new[PROD_W-1]}}, p_new};
        e_mid = {{EXT_W{p_mid[PROD_W-1]}}, p_mid};
        e_old = {{EXT_W{p_old[PROD_W-1]}}, p_old};
    end

    // Add the extended products; two's complement makes this exact.
    always_comb begin
        sum = $signed(e_new + e_mid + e_old);
    end
endmodule

// File: rtl/fir3p_carry_regs.sv
// Module: keeps the last CARRY samples of the previous valid block.
// Assumes: tail_in[i] holds the lane that becomes carry_q[i], with index 0 the
// oldest. The registers load only on a valid block and clear on reset.
module fir3p_carry_regs #(
    parameter int DATA_W = 16,
    parameter int CARRY  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CARRY-1:0][DATA_W-1:0]  tail_in,
    output logic [CARRY-1:0][DATA_W-1:0]  carry_q
);
    genvar gi;
    generate
        for (gi = 0; gi < CARRY; gi++) begin : g_carry
            // One register per carried sample; holds between valid blocks.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    carry_q[gi] <= '0;
                else if (load)
                    carry_q[gi] <= tail_in[gi];
            end
        end
    endgenerate

    // R4: a valid block leaves its tail lanes in the carry registers.
    a_r4_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> carry_q == $past(tail_in));

    // R7: without a valid block the carry registers do not move.
    a_r7_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(carry_q));
endmodule

// File: rtl/fir3p_block_filter.sv
// Module: top of the three-lane block FIR filter. Lane j adds
// A*w[j+2] + B*w[j+1] + C*w[j] over a window built from the two carried
// samples and the three current lanes. Results are registered.
// Assumes: a block, its coefficients and in_valid arrive in the same cycle.
module fir3p_block_filter
    import fir3p_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_x0,
    input  logic signed [DATA_W-1:0] in_x1,
    input  logic signed [DATA_W-1:0] in_x2,
    input  logic signed [COEF_W-1:0] coef_a,
    input  logic signed [COEF_W-1:0] coef_b,
    input  logic signed [COEF_W-1:0] coef_c,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_y0,
    output logic signed [ACC_W-1:0]  out_y1,
    output logic signed [ACC_W-1:0]  out_y2
);
    logic [LANES-1:0][DATA_W-1:0] lane_x;
    logic [CARRY-1:0][DATA_W-1:0] tail;
    logic [CARRY-1:0][DATA_W-1:0] carry_q;
    logic [WIN-1:0][DATA_W-1:0]   win;
    logic [LANES-1:0][ACC_W-1:0]  lane_sum;
    logic [LANES-1:0][ACC_W-1:0]  y_q;
    logic                         vld_q;

    // Gather the input lanes into one vector, oldest first.
    always_comb begin
        lane_x[0] = in_x0;
        lane_x[1] = in_x1;
        lane_x[2] = in_x2;
    end

    genvar gi;
    generate
        // The last CARRY lanes of this block feed the carry registers.
        for (gi = 0; gi < CARRY; gi++) begin : g_tail
            assign tail[gi] = lane_x[LANES-CARRY+gi];
        end
        // Window: carried samples first, then the current lanes.
        for (gi = 0; gi < WIN; gi++) begin : g_win
            if (gi < CARRY) begin : g_old
                assign win[gi] = carry_q[gi];
            end else begin : g_cur
                assign win[gi] = lane_x[gi-CARRY];
            end
        end
    endgenerate

    fir3p_carry_regs #(
        .DATA_W (DATA_W),
        .CARRY  (CARRY)
    ) u_carry (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .tail_in (tail),
        .carry_q (carry_q)
    );

    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            logic signed [ACC_W-1:0] s;
            fir3p_tap_sum #(
                .DATA_W (DATA_W),
                .COEF_W (COEF_W),
                .ACC_W  (ACC_W)
            ) u_sum (
                .s_new (win[gi+2]),
                .s_mid (win[gi+1]),
                .s_old (win[gi]),
                .k_new (coef_a),
                .k_mid (coef_b),
                .k_old (coef_c),
                .sum   (s)
            );
            assign lane_sum[gi] = s;

            // Result register per lane; loads on a valid block, else holds.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    y_q[gi] <= '0;
                else if (in_valid)
                    y_q[gi] <= lane_sum[gi];
            end
        end
    endgenerate

    // Output valid flag: one clock behind the input valid.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else
            vld_q <= in_valid;
    end

    assign out_valid = vld_q;
    assign out_y0    = y_q[0];
    assign out_y1    = y_q[1];
    assign out_y2    = y_q[2];

    // R5: every valid block yields a valid result one clock later.
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5: no result is flagged without a block the clock before.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: results hold across gaps.
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2)));

    // R6: reset clears the flag and all result lanes.
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_y0 == '0 && out_y1 == '0 && out_y2 == '0));
endmodule

// File: tb/fir3p_block_filter_bench.sv
`timescale 1ns/1ps
module fir3p_block_filter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_x0 = '0, in_x1 = '0, in_x2 = '0;
    logic signed [15:0] coef_a = '0, coef_b = '0, coef_c = '0;
    logic out_valid;
    logic signed [33:0] out_y0, out_y1, out_y2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        longint y [3];
        string  tag;
    } exp_t;
    exp_t sb [$];

    // Bench model of carried samples and last results (from R1-R4, R6).
    longint m1 = 0, m2 = 0;
    longint last_y [3] = '{0, 0, 0};

    always #4 clk = ~clk;

    fir3p_block_filter u_fir3p_block_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: compute expected lanes, queue them, present the block.
    task automatic send(input int x0, input int x1, input int x2,
                        input int a, input int b, input int c, input string tag);
        exp_t e;
        longint w [5];
        @(negedge clk);
        w[0] = m2; w[1] = m1; w[2] = x0; w[3] = x1; w[4] = x2;
        for (int j = 0; j < 3; j++)
            e.y[j] = longint'(a) * w[j+2] + longint'(b) * w[j+1] + longint'(c) * w[j];
        e.tag = tag;
        m2 = x1;
        m1 = x2;
        last_y = e.y;
        sb.push_back(e);
        in_x0 = 16'(x0); in_x1 = 16'(x1); in_x2 = 16'(x2);
        coef_a = 16'(a); coef_b = 16'(b); coef_c = 16'(c);
        in_valid = 1'b1;
    endtask

    // Gap of n cycles with junk on the lanes (R7); results must hold (R8).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check(out_valid == 1'b0, "R8 valid low in gap", longint'(out_valid), 0);
                check(out_y0 == last_y[0], "R8 lane0 hold", out_y0, last_y[0]);
                check(out_y1 == last_y[1], "R8 lane1 hold", out_y1, last_y[1]);
                check(out_y2 == last_y[2], "R8 lane2 hold", out_y2, last_y[2]);
            end
            in_valid = 1'b0;
            in_x0 = 16'($urandom); in_x1 = 16'($urandom); in_x2 = 16'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R6 valid after reset", longint'(out_valid), 0);
        check(out_y0 == 0 && out_y1 == 0 && out_y2 == 0, "R6 lanes zero after reset",
              out_y0 | out_y1 | out_y2, 0);
        m1 = 0; m2 = 0;
        last_y = '{0, 0, 0};
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare whenever a result is flagged (R1, R2, R3, R5).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_y0 == e.y[0], {"R1 lane0 ", e.tag}, out_y0, e.y[0]);
                check(out_y1 == e.y[1], {"R2 lane1 ", e.tag}, out_y1, e.y[1]);
                check(out_y2 == e.y[2], {"R3 lane2 ", e.tag}, out_y2, e.y[2]);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R6 valid in reset", longint'(out_valid), 0);
        check(out_y2 == 0, "R6 lane2 in reset", out_y2, 0);
        rst_n = 1'b1;

        // First block after reset sees zero history (R6).
        send(10, 20, 30, 3, -5, 7, "R6 first block");
        // Back-to-back blocks exercise the carry path (R4).
        send(-4, 9, 100, 3, -5, 7, "R4 carry");
        send(1000, -2000, 3000, 3, -5, 7, "R4 carry 2");
        // Gap with junk lanes, then a block depending on the held carry (R7).
        idle(4);
        send(1, 2, 3, 3, -5, 7, "R7 after gap");
        // Coefficient changes take effect with their block (R10).
        send(11, 22, 33, 1, 0, 0, "R10 coef A only");
        send(5, 6, 7, 0, 1, 0, "R10 coef B only");
        send(8, 9, 10, 0, 0, 1, "R10 coef C only");
        // Full-scale operands (R9).
        send(-32768, -32768, -32768, -32768, -32768, -32768, "R9 all min");
        send(-32768, -32768, -32768, -32768, -32768, -32768, "R9 all min carried");
        send(32767, 32767, 32767, -32768, -32768, -32768, "R9 max data min coef");
        idle(2);
        // Random blocks with occasional gaps.
        for (int n = 0; n < 300; n++) begin
            send(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                 int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                 int'($signed(16'($urandom))), int'($signed(16'($urandom))), "random");
            if (($urandom % 5) == 0) idle(1 + $urandom % 3);
        end
        idle(2);
        // Reset mid-run clears carried samples (R6).
        do_reset();
        send(7, 7, 7, 2, 3, 4, "R6 after mid reset");
        idle(3);
        check(sb.size() == 0, "R5 all results delivered", sb.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule